// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block sits in front of the register port of an I2C controller. When software or a supervisor finds the bus stuck, it pulses a start input and the block runs a fixed recovery pass over a simple register bus. A pass has five accesses. It forces master mode while the controller is disabled. It then enables the controller as master. It does one dummy read of the data register. It drops back to enabled slave mode. Last, it reads the status register to sample the bus-busy bit.

If the busy bit has cleared, the block finishes with success. If the bit is still set, the block runs another pass, up to a limit on the number of passes. If the bus is still busy after the last allowed pass, the block finishes with failure. Every access waits for the responder's ready before the block moves on. A programmable number of idle clocks separates consecutive accesses.

Top module: `busrec_seq`

## Requirements
- R1: After reset, busy_o, reg_valid_o, done_o, ok_o and fail_o are all low.
- R2: A one-cycle start_i in the idle state makes busy_o high on the next cycle. In that same cycle the first request is a write (reg_write_o=1) of 0x20 to the control offset.
- R3: Each pass issues exactly five accesses in this order: write 0x20 to control, write 0xA0 to control, read from the data offset, write 0x80 to control, read from the status offset.
- R4: While reg_valid_o is high and reg_ready_i is low, the request holds: valid, write flag, address and write data do not change.
- R5: An access completes in a cycle where reg_valid_o and reg_ready_i are both high. After each completed access that is followed by another, reg_valid_o stays low for exactly gap_cycles_i clocks before the next request. A gap of 0 gives a request on the very next cycle.
- R6: If the status read returns the busy bit (bit 5 by default) clear, done_o pulses on the following cycle and ok_o goes high.
- R7: If the status read returns the busy bit set, a new pass begins. This happens at most MAX_PASS times in total (9 by default). If the busy bit is still set after the last pass, done_o pulses and fail_o goes high.
- R8: done_o is high for exactly one cycle. ok_o and fail_o are never high together, and each holds its value until the next accepted start.
- R9: A start_i that arrives while busy_o is high has no effect on the access sequence or the outcome.
- R10: The value returned by the data-register read is discarded. It has no effect on the sequence or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run recovery |
| gap_cycles_i | input | GAP_W | Idle clocks between register accesses |
| reg_valid_o | output | 1 | Register request valid |
| reg_write_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W | Register offset |
| reg_wdata_o | output | DATA_W | Write data |
| reg_ready_i | input | 1 | Responder accepts the access |
| reg_rdata_i | input | DATA_W | Read data, valid with ready |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last run freed the bus |
| fail_o | output | 1 | Last run gave up with the bus still busy |

## Verification
The bench uses the default parameters: a pass limit of 9, the busy flag at bit 5, and control, status and data at offsets 0x00, 0x04 and 0x08. Under these settings, a responder that keeps the flag set for more than nine status reads drives the block through its full 45-access failure path. The bench also varies the gap from 0 to 3 clocks and the ready latency from 0 to 2 clocks. This covers back-to-back requests, requests held stable across wait cycles, and gaps between passes. The data read returns values with bit 5 both set and clear, which shows that the dummy read cannot steer the outcome.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } seq_state_t;

  localparam int STEPS_PER_PASS = 5;
  localparam int STEP_W         = 3;

  localparam logic [2:0] STEP_MST_OFF = 3'd0;
  localparam logic [2:0] STEP_MST_ON  = 3'd1;
  localparam logic [2:0] STEP_DUMMY   = 3'd2;
  localparam logic [2:0] STEP_SLV_ON  = 3'd3;
  localparam logic [2:0] STEP_POLL    = 3'd4;

  // Control byte written at a given step (zero for read steps)
  function automatic logic [7:0] step_ctrl_byte(input logic [2:0] step);
    case (step)
      STEP_MST_OFF: step_ctrl_byte = 8'h20;
      STEP_MST_ON:  step_ctrl_byte = 8'hA0;
      STEP_SLV_ON:  step_ctrl_byte = 8'h80;
      default:      step_ctrl_byte = 8'h00;
    endcase
  endfunction

  function automatic logic step_is_write(input logic [2:0] step);
    step_is_write = (step != STEP_DUMMY) && (step != STEP_POLL);
  endfunction

  function automatic logic step_is_last(input logic [2:0] step);
    step_is_last = (step == STEP_POLL);
  endfunction

endpackage

// File: rtl/busrec_gap_timer.sv
module busrec_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             gap_end
);
  logic [GAP_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain_q <= '0;
    else if (load)             remain_q <= load_val;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  // Last idle clock of a loaded gap
  assign gap_end = (remain_q == GAP_W'(1));
endmodule

// File: rtl/busrec_pass_counter.sv
module busrec_pass_counter #(
  parameter int MAX_PASS = 9,
  parameter int PASS_W   = $clog2(MAX_PASS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first,
  input  logic              advance,
  output logic [PASS_W-1:0] pass_num,
  output logic              at_limit
);
  logic [PASS_W-1:0] num_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       num_q <= '0;
    else if (first)   num_q <= PASS_W'(1);
    else if (advance) num_q <= num_q + 1'b1;
  end

  assign pass_num = num_q;
  assign at_limit = (num_q >= PASS_W'(MAX_PASS));
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [7:0]      CTRL_ADDR = 8'h00,
  parameter logic [7:0]      STAT_ADDR = 8'h04,
  parameter logic [7:0]      DATA_ADDR = 8'h08,
  parameter int              BUSY_BIT  = 5,
  parameter int              MAX_PASS  = 9,
  parameter int              GAP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [GAP_W-1:0]  gap_cycles_i,
  output logic              reg_valid_o,
  output logic              reg_write_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic              reg_ready_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              fail_o
);
  localparam int PASS_W = $clog2(MAX_PASS + 1);

  seq_state_t        state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q, ok_q, fail_q;

  // Named internal events
  logic              launch;
  logic              acc_fire;
  logic              stat_fire;
  logic              bus_still_busy;
  logic              gap_end;
  logic              need_gap;
  logic              retry;
  logic              finish;
  logic [PASS_W-1:0] pass_cnt;
  logic              pass_limit;

  assign launch         = (state_q == ST_IDLE) && start_i;
  assign acc_fire       = (state_q == ST_ACCESS) && reg_ready_i;
  assign stat_fire      = acc_fire && step_is_last(step_q);
  assign bus_still_busy = reg_rdata_i[BUSY_BIT];
  assign finish         = stat_fire && (!bus_still_busy || pass_limit);
  assign retry          = stat_fire && bus_still_busy && !pass_limit;
  assign need_gap       = (gap_cycles_i != '0);

  busrec_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_fire && !finish),
    .load_val (gap_cycles_i),
    .gap_end  (gap_end)
  );

  busrec_pass_counter #(.MAX_PASS(MAX_PASS), .PASS_W(PASS_W)) u_pass (
    .clk      (clk),
    .rst_n    (rst_n),
    .first    (launch),
    .advance  (retry),
    .pass_num (pass_cnt),
    .at_limit (pass_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_q <= ST_ACCESS;
            step_q  <= STEP_MST_OFF;
            ok_q    <= 1'b0;
            fail_q  <= 1'b0;
          end
        end
        ST_ACCESS: begin
          if (finish) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            ok_q    <= !bus_still_busy;
            fail_q  <= bus_still_busy;
          end else if (acc_fire) begin
            step_q  <= retry ? STEP_MST_OFF : step_q + 1'b1;
            state_q <= need_gap ? ST_GAP : ST_ACCESS;
          end
        end
        ST_GAP: begin
          if (gap_end) state_q <= ST_ACCESS;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_valid_o = (state_q == ST_ACCESS);
    reg_write_o = reg_valid_o && step_is_write(step_q);
    reg_wdata_o = reg_write_o ? DATA_W'(step_ctrl_byte(step_q)) : '0;
    if (!reg_valid_o)               reg_addr_o = '0;
    else if (step_q == STEP_DUMMY)  reg_addr_o = ADDR_W'(DATA_ADDR);
    else if (step_q == STEP_POLL)   reg_addr_o = ADDR_W'(STAT_ADDR);
    else                            reg_addr_o = ADDR_W'(CTRL_ADDR);
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/busrec_seq_chk.sv
module busrec_seq_chk #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] CTRL_ADDR = 8'h00,
  parameter logic [7:0] STAT_ADDR = 8'h04,
  parameter int         BUSY_BIT  = 5,
  parameter int         MAX_PASS  = 9,
  parameter int         PASS_W    = $clog2(MAX_PASS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              reg_valid_o,
  input logic              reg_write_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              reg_ready_i,
  input logic [DATA_W-1:0] reg_rdata_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ok_o,
  input logic              fail_o,
  input logic              stat_fire,
  input logic [PASS_W-1:0] pass_cnt
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !reg_valid_o);

  p_first_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> reg_valid_o && reg_write_o &&
      reg_addr_o == ADDR_W'(CTRL_ADDR) && reg_wdata_o == DATA_W'(8'h20));

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid_o && !reg_ready_i |=> reg_valid_o && $stable(reg_write_o) &&
      $stable(reg_addr_o) && $stable(reg_wdata_o));

  p_ok_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ok_o |-> $past(stat_fire) && !$past(reg_rdata_i[BUSY_BIT]));

  p_status_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire |-> !reg_write_o && reg_addr_o == ADDR_W'(STAT_ADDR));

  p_fail_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fail_o |-> $past(stat_fire) && $past(reg_rdata_i[BUSY_BIT]) &&
      $past(pass_cnt) == PASS_W'(MAX_PASS));

  p_pass_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> pass_cnt != '0 && pass_cnt <= PASS_W'(MAX_PASS));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_ok_fail_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && fail_o));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !stat_fire |=> busy_o);
endmodule

bind busrec_seq busrec_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
  .STAT_ADDR(STAT_ADDR), .BUSY_BIT(BUSY_BIT), .MAX_PASS(MAX_PASS),
  .PASS_W(PASS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .reg_valid_o(reg_valid_o), .reg_write_o(reg_write_o),
  .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
  .reg_ready_i(reg_ready_i), .reg_rdata_i(reg_rdata_i),
  .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .fail_o(fail_o),
  .stat_fire(stat_fire), .pass_cnt(pass_cnt)
);

// File: tb/busrec_seq_tb_top.sv
module busrec_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] gap_cycles_i = 8'd0;
  logic       reg_valid_o, reg_write_o;
  logic [7:0] reg_addr_o, reg_wdata_o;
  logic       reg_ready_i;
  logic [7:0] reg_rdata_i;
  logic       busy_o, done_o, ok_o, fail_o;

  always #10 clk = ~clk;

  busrec_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gap_cycles_i(gap_cycles_i),
    .reg_valid_o(reg_valid_o), .reg_write_o(reg_write_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_ready_i(reg_ready_i), .reg_rdata_i(reg_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .fail_o(fail_o)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Responder: ready after lat waiting cycles; status busy for busy_reads reads
  int  lat = 0, wait_n = 0, busy_reads = 0, stat_reads = 0;
  logic [7:0] dummy_val = 8'h00;
  assign reg_ready_i = reg_valid_o && (wait_n >= lat);
  assign reg_rdata_i = (reg_addr_o == 8'h04) ? ((stat_reads < busy_reads) ? 8'h20 : 8'h00)
                     : (reg_addr_o == 8'h08) ? dummy_val : 8'h00;
  always @(posedge clk) begin
    if (reg_valid_o && reg_ready_i) begin
      wait_n <= 0;
      if (reg_addr_o == 8'h04) stat_reads <= stat_reads + 1;
    end else if (reg_valid_o) wait_n <= wait_n + 1;
  end

  // Behavioural reference: expected access list is a queue refilled per pass
  int  exp_wr[$], exp_addr[$], exp_dat[$];
  bit  m_run = 0, m_done = 0, m_ok = 0, m_fail = 0;
  int  m_idle_left = 0, m_passes = 0;
  int  acc_count = 0;
  bit  prev_wait = 0;
  logic [7:0] prev_addr, prev_wdata; logic prev_wr;

  task automatic push_pass();
    exp_wr.push_back(1); exp_addr.push_back(8'h00); exp_dat.push_back(8'h20);
    exp_wr.push_back(1); exp_addr.push_back(8'h00); exp_dat.push_back(8'hA0);
    exp_wr.push_back(0); exp_addr.push_back(8'h08); exp_dat.push_back(8'h00);
    exp_wr.push_back(1); exp_addr.push_back(8'h00); exp_dat.push_back(8'h80);
    exp_wr.push_back(0); exp_addr.push_back(8'h04); exp_dat.push_back(8'h00);
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ev;
    cycles++;
    ev = m_run && (m_idle_left == 0);
    // compare against model
    chk(reg_valid_o === ev, "R5 valid/gap", reg_valid_o, ev);
    chk(busy_o === m_run, "R2 busy", busy_o, m_run);
    chk(done_o === m_done, "R8 done", done_o, m_done);
    chk(ok_o === m_ok, "R6 ok", ok_o, m_ok);
    chk(fail_o === m_fail, "R7 fail", fail_o, m_fail);
    if (ev && exp_wr.size() > 0) begin
      chk(reg_write_o === exp_wr[0][0], "R3 write", reg_write_o, exp_wr[0]);
      chk(reg_addr_o == exp_addr[0], "R3 addr", reg_addr_o, exp_addr[0]);
      if (exp_wr[0] == 1) chk(reg_wdata_o == exp_dat[0], "R3 wdata", reg_wdata_o, exp_dat[0]);
    end
    if (prev_wait)
      chk(reg_valid_o && reg_write_o == prev_wr && reg_addr_o == prev_addr &&
          reg_wdata_o == prev_wdata, "R4 hold", reg_addr_o, prev_addr);
    prev_wait = reg_valid_o && !reg_ready_i;
    prev_wr = reg_write_o; prev_addr = reg_addr_o; prev_wdata = reg_wdata_o;
    // predict the next cycle
    m_done = 0;
    if (!m_run) begin
      if (start_i) begin
        m_run = 1; m_ok = 0; m_fail = 0; m_passes = 1; m_idle_left = 0;
        exp_wr.delete(); exp_addr.delete(); exp_dat.delete();
        push_pass();
      end
    end else if (m_idle_left > 0) begin
      m_idle_left--;
    end else if (reg_ready_i) begin
      acc_count++;
      if (exp_addr.size() > 0 && exp_addr[0] == 8'h04) begin
        if (!reg_rdata_i[5]) begin m_run = 0; m_done = 1; m_ok = 1; end
        else if (m_passes == 9) begin m_run = 0; m_done = 1; m_fail = 1; end
        else begin m_passes++; push_pass(); m_idle_left = gap_cycles_i; end
      end else m_idle_left = gap_cycles_i;
      void'(exp_wr.pop_front()); void'(exp_addr.pop_front()); void'(exp_dat.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run(input int gap, input int l, input int br, input logic [7:0] dv,
                     input bit poke, input int exp_acc, input bit exp_ok, input string tag);
    int guard = 0;
    gap_cycles_i = 8'(gap); lat = l; busy_reads = br; stat_reads = 0; dummy_val = dv;
    acc_count = 0;
    tick(1); start_i = 1; tick(1); start_i = 0;
    if (poke) begin tick(7); start_i = 1; tick(1); start_i = 0; end
    while (!done_o && guard < 20000) begin tick(1); guard++; end
    chk(acc_count == exp_acc, {tag, " access count"}, acc_count, exp_acc);
    chk(ok_o == exp_ok && fail_o == !exp_ok, {tag, " outcome"}, ok_o, exp_ok);
    tick(1);
    chk(!done_o, "R8 done pulse width", done_o, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    #5;
    chk(!busy_o && !reg_valid_o && !done_o && !ok_o && !fail_o, "R1 reset state", busy_o, 0);
    tick(1);
    // R6 and R10: bus frees after the first pass; dummy data has bit 5 set
    run(0, 0, 0, 8'hFF, 0, 5, 1, "R6");
    tick(5);
    chk(ok_o && !fail_o, "R8 ok held", ok_o, 1);
    // R7 and R9: two busy polls, gaps, latency, and a start poked mid-run
    run(3, 2, 2, 8'h00, 1, 15, 1, "R9");
    // R7: never frees, limit of nine passes reached
    run(1, 1, 100, 8'h20, 0, 45, 0, "R7");
    tick(4);
    chk(fail_o && !ok_o, "R8 fail held", fail_o, 1);
    // R10: same run as the first with dummy data clear gives same result
    run(2, 1, 0, 8'h00, 0, 5, 1, "R10");
    tick(3);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule